// File: doc/BRIEF.md
# Processor Power-Up Reset Sequencer

This block runs on the processor bus clock and controls the power-good, reset and configuration-strap outputs of one processor socket during power-up. It waits until the supplies, which it sees as one digital "rails good" input, are in tolerance and the bus clock is reported stable. It then keeps power-good low for a minimum number of clocks and raises it once. After power-good rises it waits at least one millisecond, counted in bus clocks. It drives the strap values for a setup window while reset is still asserted, releases reset, and keeps the straps driven for a hold window that software sets. When that window ends it disables the strap drivers and flags completion.

A waiver input skips the clock-settle wait when the board can guarantee the clock settles in time. Power-good still waits for the rails. If the rails drop at any point, the sequencer returns to its idle state: power-good low, reset asserted and straps released. It restarts when the rails come back.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While `arst_n` is low, and while idle after it is released, `pwr_ok`, `cpu_rst_n`, `strap_oe` and `seq_done` are all 0.
- R2: With `settle_waiver` low, `pwr_ok` stays 0 until an edge samples both `rails_ok` and `clk_stable` high. It then becomes 1 on the edge PG_LOW_CYC (10) cycles after that edge.
- R3: With `settle_waiver` high, `pwr_ok` ignores `clk_stable`. It becomes 1 on the first edge that samples `rails_ok` high, and stays 0 while `rails_ok` is low.
- R4: `cpu_rst_n` becomes 1 exactly MS_CYC + SETUP_CYC cycles after `pwr_ok` rises. MS_CYC equals CLK_KHZ, which is one millisecond. SETUP_CYC is 4.
- R5: `strap_oe` becomes 1 exactly MS_CYC cycles after `pwr_ok` rises, which is SETUP_CYC cycles before reset is released. `strap_out` then equals the `strap_val` sampled on that edge.
- R6: While `strap_oe` is 1, `strap_out` holds its captured value and ignores changes on `strap_val`.
- R7: `strap_oe` stays 1 for H cycles after the edge that raises `cpu_rst_n`. On the next edge `strap_oe` becomes 0 and `seq_done` becomes 1. H is the clamped `hold_cfg` value sampled with the straps.
- R8: H is `hold_cfg` clamped to the range 2..20: values 0 and 1 give 2, and values above 20 give 20.
- R9: An edge that samples `rails_ok` low sets `pwr_ok`, `cpu_rst_n`, `strap_oe` and `seq_done` to 0, and the sequence starts again from idle.
- R10: `pwr_ok` never falls unless `rails_ok` was sampled low, and reset is only released while power-good and the straps are driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| arst_n | input | 1 | Asynchronous active-low controller reset |
| rails_ok | input | 1 | All supply rails in tolerance |
| clk_stable | input | 1 | Bus clock meets its timing |
| settle_waiver | input | 1 | Skip the clock-settle power-good wait |
| hold_cfg | input | HW (5) | Requested strap hold length in cycles |
| strap_val | input | SW (8) | Configuration strap values to present |
| pwr_ok | output | 1 | Power-good to the processor |
| cpu_rst_n | output | 1 | Active-low processor reset |
| strap_out | output | SW (8) | Driven strap values (0 when not enabled) |
| strap_oe | output | 1 | Strap driver enable |
| seq_done | output | 1 | Sequence complete, straps released |

## Verification
The hardest case to reach from the ports is a loss of the rails deep inside the sequence. It must land after power-good is up but before reset is released, so that the abort has something to undo. The bench overrides CLK_KHZ to a small value so the millisecond window is short. It drops `rails_ok` at a cycle computed from the edge on which the waiver sequence started, and then checks that power-good and the other outputs fall one edge later. A separate run holds `clk_stable` low for many cycles with the rails good, to show that the 10-cycle wait does not start early.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_PGWAIT = 3'd1,
    ST_MSWAIT = 3'd2,
    ST_SETUP  = 3'd3,
    ST_HOLD   = 3'd4,
    ST_DONE   = 3'd5
  } rsq_state_e;

  // Bus-clock cycles in one millisecond for a clock given in kHz.
  function automatic int unsigned ms_cycles(input int unsigned clk_khz);
    return clk_khz;
  endfunction

  // Limit a requested hold length to [lo, hi].
  function automatic int unsigned clamp_len(input int unsigned raw,
                                            input int unsigned lo,
                                            input int unsigned hi);
    if (raw < lo) return lo;
    if (raw > hi) return hi;
    return raw;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/rsq_timer.sv
module rsq_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          load,
  input  logic [CW-1:0] load_len,
  output logic          expired
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)             cnt_q <= '0;
    else if (load)           cnt_q <= load_len - CW'(1);
    else if (cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
  end

  assign expired = (cnt_q == '0);

  // R4
  timer_no_wrap_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (!load && cnt_q == '0) |=> cnt_q == '0);
endmodule

// File: rtl/rsq_strap_drv.sv
module rsq_strap_drv #(
  parameter int SW       = 8,
  parameter int HW       = 5,
  parameter int HOLD_MIN = 2,
  parameter int HOLD_MAX = 20
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          capture,
  input  logic          drive_en,
  input  logic [SW-1:0] strap_in,
  input  logic [HW-1:0] hold_req,
  output logic [SW-1:0] strap_out,
  output logic [HW-1:0] hold_len
);
  logic [SW-1:0] strap_q;
  logic [HW-1:0] hold_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      strap_q <= '0;
      hold_q  <= HW'(HOLD_MIN);
    end else if (capture) begin
      strap_q <= strap_in;
      hold_q  <= HW'(rsq_pkg::clamp_len(int'(hold_req), HOLD_MIN, HOLD_MAX));
    end
  end

  assign strap_out = drive_en ? strap_q : '0;
  assign hold_len  = hold_q;

  // R8
  hold_range_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (int'(hold_q) >= HOLD_MIN) && (int'(hold_q) <= HOLD_MAX));
  // R6
  strap_keep_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (drive_en && !capture) |=> $stable(strap_q));
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl #(
  parameter int SW         = 8,
  parameter int HW         = 5,
  parameter int CLK_KHZ    = 100000,
  parameter int PG_LOW_CYC = 10,
  parameter int SETUP_CYC  = 4,
  parameter int HOLD_MIN   = 2,
  parameter int HOLD_MAX   = 20
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          rails_ok,
  input  logic          clk_stable,
  input  logic          settle_waiver,
  input  logic [HW-1:0] hold_cfg,
  input  logic [SW-1:0] strap_val,
  output logic          pwr_ok,
  output logic          cpu_rst_n,
  output logic [SW-1:0] strap_out,
  output logic          strap_oe,
  output logic          seq_done
);
  import rsq_pkg::*;

  localparam int MS_CYC  = int'(ms_cycles(CLK_KHZ));
  localparam int MAX_LEN = max2(max2(MS_CYC, PG_LOW_CYC), max2(SETUP_CYC, HOLD_MAX));
  localparam int CW      = $clog2(MAX_LEN + 1);

  rsq_state_e    state_q, state_d;
  logic          t_load, t_expired, capture;
  logic [CW-1:0] t_len;
  logic [HW-1:0] hold_len;
  logic          pwr_q, rst_n_q, oe_q, done_q;

  // Named events for the assertions
  logic pg_rise_ev, rst_release_ev, hold_end_ev, abort_ev;
  assign abort_ev       = !rails_ok && (state_q != ST_IDLE);
  assign pg_rise_ev     = (state_q inside {ST_IDLE, ST_PGWAIT}) && (state_d == ST_MSWAIT);
  assign rst_release_ev = (state_q == ST_SETUP) && (state_d == ST_HOLD);
  assign hold_end_ev    = (state_q == ST_HOLD) && (state_d == ST_DONE);

  always_comb begin
    state_d = state_q;
    t_load  = 1'b0;
    t_len   = '0;
    capture = 1'b0;
    if (!rails_ok) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (settle_waiver) begin
            state_d = ST_MSWAIT; t_load = 1'b1; t_len = CW'(MS_CYC);
          end else if (clk_stable) begin
            state_d = ST_PGWAIT; t_load = 1'b1; t_len = CW'(PG_LOW_CYC);
          end
        end
        ST_PGWAIT: if (t_expired) begin
          state_d = ST_MSWAIT; t_load = 1'b1; t_len = CW'(MS_CYC);
        end
        ST_MSWAIT: if (t_expired) begin
          state_d = ST_SETUP; t_load = 1'b1; t_len = CW'(SETUP_CYC); capture = 1'b1;
        end
        ST_SETUP: if (t_expired) begin
          state_d = ST_HOLD; t_load = 1'b1; t_len = CW'(hold_len);
        end
        ST_HOLD: if (t_expired) state_d = ST_DONE;
        ST_DONE: state_d = ST_DONE;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state_q <= ST_IDLE;
      pwr_q   <= 1'b0;
      rst_n_q <= 1'b0;
      oe_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pwr_q   <= state_d inside {ST_MSWAIT, ST_SETUP, ST_HOLD, ST_DONE};
      rst_n_q <= state_d inside {ST_HOLD, ST_DONE};
      oe_q    <= state_d inside {ST_SETUP, ST_HOLD};
      done_q  <= (state_d == ST_DONE);
    end
  end

  rsq_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .arst_n   (arst_n),
    .load     (t_load),
    .load_len (t_len),
    .expired  (t_expired)
  );

  rsq_strap_drv #(.SW(SW), .HW(HW), .HOLD_MIN(HOLD_MIN), .HOLD_MAX(HOLD_MAX)) u_strap (
    .clk       (clk),
    .arst_n    (arst_n),
    .capture   (capture),
    .drive_en  (oe_q),
    .strap_in  (strap_val),
    .hold_req  (hold_cfg),
    .strap_out (strap_out),
    .hold_len  (hold_len)
  );

  assign pwr_ok    = pwr_q;
  assign cpu_rst_n = rst_n_q;
  assign strap_oe  = oe_q;
  assign seq_done  = done_q;

  // Verification aid: consecutive cycles with straps driven under reset
  logic [3:0] setup_run_q;
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)                               setup_run_q <= '0;
    else if (oe_q && !rst_n_q && setup_run_q != 4'hF) setup_run_q <= setup_run_q + 4'd1;
    else if (!(oe_q && !rst_n_q))              setup_run_q <= '0;
  end

  // R10
  pwr_no_drop_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(pwr_ok) |-> !$past(rails_ok));
  // R10
  rst_needs_pg_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(cpu_rst_n) |-> (pwr_ok && strap_oe));
  // R5
  setup_window_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(cpu_rst_n) |-> (int'(setup_run_q) >= SETUP_CYC));
  // R6
  strap_stable_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (strap_oe && $past(strap_oe)) |-> $stable(strap_out));
  // R7
  done_clean_chk: assert property (@(posedge clk) disable iff (!arst_n)
    seq_done |-> (cpu_rst_n && pwr_ok && !strap_oe));
  // R9
  abort_idle_chk: assert property (@(posedge clk) disable iff (!arst_n)
    abort_ev |=> (!pwr_ok && !cpu_rst_n && !strap_oe && !seq_done));
  // R2
  pg_rise_once_chk: assert property (@(posedge clk) disable iff (!arst_n)
    pg_rise_ev |-> !pwr_ok);
  // R7
  hold_end_chk: assert property (@(posedge clk) disable iff (!arst_n)
    hold_end_ev |-> (strap_oe && cpu_rst_n));
  // R4
  release_chk: assert property (@(posedge clk) disable iff (!arst_n)
    rst_release_ev |=> cpu_rst_n);
endmodule

// File: tb/sim_rst_seq_ctrl.sv
module sim_rst_seq_ctrl;
  localparam int SW = 8, HW = 5, KHZ = 50;

  logic clk = 1'b0, arst_n = 1'b0;
  logic rails_ok = 1'b0, clk_stable = 1'b0, settle_waiver = 1'b0;
  logic [HW-1:0] hold_cfg = '0;
  logic [SW-1:0] strap_val = '0;
  logic pwr_ok, cpu_rst_n, strap_oe, seq_done;
  logic [SW-1:0] strap_out;

  always #4 clk = ~clk;   // 125 MHz

  rst_seq_ctrl #(.SW(SW), .HW(HW), .CLK_KHZ(KHZ)) u0 (
    .clk(clk), .arst_n(arst_n), .rails_ok(rails_ok), .clk_stable(clk_stable),
    .settle_waiver(settle_waiver), .hold_cfg(hold_cfg), .strap_val(strap_val),
    .pwr_ok(pwr_ok), .cpu_rst_n(cpu_rst_n), .strap_out(strap_out),
    .strap_oe(strap_oe), .seq_done(seq_done)
  );

  typedef struct { int cyc; int fld; int val; string tag; } item_t;
  item_t q[$];
  int cyc = 0, n_chk = 0, n_fail = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int clampv(int v);
    return (v < 2) ? 2 : (v > 20) ? 20 : v;
  endfunction

  function automatic int probe(int fld);
    case (fld)
      0: return int'(pwr_ok);
      1: return int'(cpu_rst_n);
      2: return int'(strap_oe);
      3: return int'(seq_done);
      default: return int'(strap_out);
    endcase
  endfunction

  task automatic expect_at(int c, int fld, int val, string tag);
    item_t it;
    it.cyc = c; it.fld = fld; it.val = val; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic wait_to(int c);
    while (cyc < c) @(negedge clk);
  endtask

  // Monitor: pops due items and compares at the falling edge
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      item_t it;
      int act;
      it = q.pop_front();
      act = probe(it.fld);
      n_chk++;
      if (it.cyc != cyc || act != it.val) begin
        n_fail++;
        $display("FAIL %s cyc=%0d field=%0d actual=%0h expected=%0h",
                 it.tag, it.cyc, it.fld, act, it.val);
      end
    end
  end

  task automatic finish_run();
    if (finished) return;
    finished = 1;
    if (q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL R1 unchecked items actual=%0d expected=0", q.size());
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int e, m, h, s;
    // R1: reset state while arst_n low and while idle
    @(negedge clk);
    n_chk++;
    if ({pwr_ok, cpu_rst_n, strap_oe, seq_done} != 4'b0) begin
      n_fail++;
      $display("FAIL R1 reset outputs actual=%b expected=0000",
               {pwr_ok, cpu_rst_n, strap_oe, seq_done});
    end
    wait_to(3);
    arst_n = 1'b1;
    expect_at(5, 0, 0, "R1"); expect_at(5, 1, 0, "R1");
    wait_to(5);
    // Run 1: normal sequence, hold 5, straps A5 then changed mid-hold
    rails_ok = 1; clk_stable = 1; settle_waiver = 0; hold_cfg = 5; strap_val = 8'hA5;
    e = cyc + 1; h = 5;
    expect_at(e + 9, 0, 0, "R2");
    expect_at(e + 10, 0, 1, "R2");
    expect_at(e + 40, 0, 1, "R10");
    expect_at(e + 59, 2, 0, "R5");
    expect_at(e + 60, 2, 1, "R5");
    expect_at(e + 60, 4, 'hA5, "R5");
    expect_at(e + 63, 1, 0, "R4");
    expect_at(e + 64, 1, 1, "R4");
    expect_at(e + 64 + h - 1, 2, 1, "R7");
    expect_at(e + 64 + h - 1, 4, 'hA5, "R6");
    expect_at(e + 64 + h, 2, 0, "R7");
    expect_at(e + 64 + h, 3, 1, "R7");
    wait_to(e + 61);
    strap_val = 8'h3C;
    wait_to(e + 64 + h + 3);
    // Run 2: rails loss after done, then waiver sequence, hold 0 -> 2
    m = cyc;
    expect_at(m + 1, 0, 0, "R9"); expect_at(m + 1, 1, 0, "R9");
    expect_at(m + 1, 3, 0, "R9");
    expect_at(m + 3, 0, 0, "R3");
    rails_ok = 0; clk_stable = 0; settle_waiver = 1; hold_cfg = 0; strap_val = 8'h5A;
    wait_to(m + 3);
    rails_ok = 1;
    e = cyc + 1; h = clampv(0);
    expect_at(e, 0, 1, "R3");
    expect_at(e + 49, 2, 0, "R5");
    expect_at(e + 50, 2, 1, "R5");
    expect_at(e + 50, 4, 'h5A, "R5");
    expect_at(e + 54, 1, 1, "R4");
    expect_at(e + 54 + h - 1, 2, 1, "R8");
    expect_at(e + 54 + h, 2, 0, "R8");
    expect_at(e + 54 + h, 3, 1, "R7");
    wait_to(e + 60);
    // Run 3: no waiver, clk_stable late, hold 31 -> 20
    m = cyc;
    expect_at(m + 1, 3, 0, "R9");
    rails_ok = 0; settle_waiver = 0; clk_stable = 0; hold_cfg = 31; strap_val = 8'hC3;
    wait_to(m + 2);
    rails_ok = 1;
    expect_at(m + 22, 0, 0, "R2");
    wait_to(m + 22);
    clk_stable = 1;
    e = cyc + 1; h = clampv(31);
    expect_at(e + 9, 0, 0, "R2");
    expect_at(e + 10, 0, 1, "R2");
    expect_at(e + 60, 4, 'hC3, "R5");
    expect_at(e + 64, 1, 1, "R4");
    expect_at(e + 64 + h - 1, 2, 1, "R8");
    expect_at(e + 64 + h, 2, 0, "R8");
    expect_at(e + 64 + h, 3, 1, "R7");
    wait_to(e + 64 + h + 3);
    // Run 4: abort in the millisecond window after power-good rose
    m = cyc;
    rails_ok = 0; settle_waiver = 1;
    wait_to(m + 2);
    rails_ok = 1;
    e = cyc + 1;
    expect_at(e - 1, 3, 0, "R9");
    expect_at(e, 0, 1, "R3");
    expect_at(e + 21, 0, 0, "R9");
    expect_at(e + 22, 1, 0, "R9");
    expect_at(e + 22, 2, 0, "R9");
    wait_to(e + 20);
    rails_ok = 0;
    wait_to(e + 26);
    finish_run();
  end
endmodule